// File: doc/BRIEF.md
# Banked Coefficient Store

This block holds the coefficient sets of a multi-tap filter. Sixteen banks of sixteen twelve-bit coefficients sit behind a sixteen-bit register bus. One configuration register selects the bank that bus writes land in. The same register also selects the bank the filter runs from, along with a mode field and a decimation code. A second register holds a sixteen-bit output gain. A coefficient write word carries its own in-bank index in its top nibble, so one bus address serves every coefficient of the bank being loaded.

Every coefficient of the running bank is presented at once on a wide registered output. That output changes only on a sample boundary, which the datapath marks with a one-cycle tick. Because of this, one filter output never mixes two coefficient sets, whether software switches banks or rewrites the running bank. The bus can be strapped for two timing styles. In the first, separate active-low read and write strobes are used. In the second, a read/write level is qualified by an active-low data strobe.

Top module: `coef_bank_store`

## Requirements
- R1: While `rst` is high, and after it is released, the configuration and gain registers read 0, `coef_out` is 0, `active_bank_out` is 0 and `rdata` is 0.
- R2: A write to any address with bit 4 set stores `wdata[11:0]` at index `wdata[15:12]` of the load bank. A read at address 16+k returns index k of the load bank, zero-extended to 16 bits.
- R3: The bank that receives coefficient writes is taken only from the load field of the configuration register. Writes to one bank leave every other bank unchanged.
- R4: The configuration register sits at address 0 and holds four fields: load bank in bits 3:0, active bank in bits 7:4, mode in bits 9:8 and decimation code in bits 12:10. It reads back with bits 15:13 as 0, and `mode_out`/`decim_out` follow it.
- R5: A decimation code above 4 is stored as 4.
- R6: The gain register sits at address 1, holds all 16 written bits, reads back and drives `gain_out`.
- R7: One clock after `sample_tick` is high, `coef_out` holds every coefficient of the active bank at once, with index i in bits 12i+11:12i, and `active_bank_out` holds that bank number. Bank switches and coefficient writes must be accepted at least two clocks before the tick.
- R8: Between ticks, `coef_out` and `active_bank_out` do not change, even when the active bank field or the active bank's contents are written.
- R9: With `bus_mode`=0, `rd_rw` is an active-low read strobe and `wr_ds_n` an active-low write strobe. With `bus_mode`=1, `wr_ds_n` is an active-low data strobe and `rd_rw` selects read (1) or write (0).
- R10: A write strobe held for several clocks performs exactly one write, on its first clock, using the data present then.
- R11: Read data appears on `rdata` two clocks after a read is presented, and `rdata` is 0 whenever no read was active two clocks earlier.
- R12: With `bus_mode`=0, both strobes low at once performs neither a read nor a write.
- R13: With `cs_n` high, no access takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 1 | Strap: 0 separate strobes, 1 read/write level with data strobe |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rd_rw | input | 1 | Read strobe (mode 0) or read/write level (mode 1) |
| wr_ds_n | input | 1 | Write strobe (mode 0) or data strobe (mode 1) |
| rdata | output | 16 | Registered read data |
| sample_tick | input | 1 | Sample boundary marker from the datapath |
| coef_out | output | 192 | All coefficients of the running bank |
| active_bank_out | output | 4 | Bank currently driving `coef_out` |
| mode_out | output | 2 | Mode field |
| decim_out | output | 3 | Decimation code |
| gain_out | output | 16 | Gain register |

## Verification
The assertions assume that all bus inputs are synchronous to `clk`. They also assume that address and data stay stable for the first clock of a strobe, that `bus_mode` changes only while the bus is idle, and that a bank change or coefficient update is accepted at least two clocks before the tick meant to pick it up. The stimulus keeps within these limits. It changes inputs only on falling edges and holds each strobe for one full clock. It returns the bus to idle between accesses and leaves several idle clocks before every tick. The held-strobe test changes data only after the first clock of the strobe.

// File: rtl/cbank_pkg.sv
package cbank_pkg;
  localparam int BANK_W  = 4;
  localparam int IDX_W   = 4;
  localparam int COEF_W  = 12;
  localparam int BUS_W   = COEF_W + IDX_W;
  localparam int ADDR_W  = 5;
  localparam int MODE_W  = 2;
  localparam int DEC_W   = 3;
  localparam logic [DEC_W-1:0] MAX_DEC_CODE = 3'd4;

  typedef struct packed {
    logic [DEC_W-1:0]  decim;
    logic [MODE_W-1:0] mode;
    logic [BANK_W-1:0] active;
    logic [BANK_W-1:0] load;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [1:0] {RSEL_NONE = 2'd0, RSEL_CFG = 2'd1, RSEL_GAIN = 2'd2} rsel_e;

  function automatic logic [DEC_W-1:0] clamp_dec(input logic [DEC_W-1:0] code);
    return (code > MAX_DEC_CODE) ? MAX_DEC_CODE : code;
  endfunction
endpackage

// File: rtl/cbank_bus_decode.sv
module cbank_bus_decode (
  input  logic clk,
  input  logic rst,
  input  logic bus_mode,
  input  logic cs_n,
  input  logic rd_rw,
  input  logic wr_ds_n,
  output logic wr_pulse,
  output logic rd_act
);
  logic sel_rd, sel_wr, wr_seen;

  always_comb begin
    if (!bus_mode) begin
      // separate strobes; both low together is rejected (R12)
      sel_rd = !cs_n && !rd_rw && wr_ds_n;
      sel_wr = !cs_n && !wr_ds_n && rd_rw;
    end else begin
      sel_rd = !cs_n && !wr_ds_n && rd_rw;
      sel_wr = !cs_n && !wr_ds_n && !rd_rw;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr_seen <= 1'b0;
    else     wr_seen <= sel_wr;
  end

  assign wr_pulse = sel_wr && !wr_seen;
  assign rd_act   = sel_rd;

  a_r12_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wr_pulse && rd_act));
  a_r10_one_write_per_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);
  a_r13_deselected_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!wr_pulse && !rd_act));
endmodule

// File: rtl/cbank_regs.sv
module cbank_regs
  import cbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cfg,
  input  logic             wr_gain,
  input  logic [BUS_W-1:0] wdata,
  output cfg_t             cfg,
  output logic [BUS_W-1:0] gain
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= '0;
      gain <= '0;
    end else begin
      if (wr_cfg) begin
        cfg.load   <= wdata[BANK_W-1:0];
        cfg.active <= wdata[2*BANK_W-1:BANK_W];
        cfg.mode   <= wdata[2*BANK_W+MODE_W-1:2*BANK_W];
        cfg.decim  <= clamp_dec(wdata[CFG_W-1:2*BANK_W+MODE_W]);
      end
      if (wr_gain) gain <= wdata;
    end
  end

  a_r5_decim_in_range: assert property (@(posedge clk) disable iff (rst)
    cfg.decim <= MAX_DEC_CODE);
  a_r4_cfg_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_cfg |=> $stable(cfg));
  a_r6_gain_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_gain |=> $stable(gain));
endmodule

// File: rtl/cbank_lane.sv
module cbank_lane #(
  parameter int BANK_W = 4,
  parameter int CW     = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BANK_W-1:0] wbank,
  input  logic [CW-1:0]     wval,
  input  logic [BANK_W-1:0] dp_bank,
  input  logic [BANK_W-1:0] bus_bank,
  output logic [CW-1:0]     dp_q,
  output logic [CW-1:0]     bus_q
);
  localparam int NBANK = 1 << BANK_W;

  logic [CW-1:0] mem [NBANK];

  // one write port, two synchronous read ports, no reset on storage
  always_ff @(posedge clk) begin
    if (we) mem[wbank] <= wval;
    dp_q  <= mem[dp_bank];
    bus_q <= mem[bus_bank];
  end
endmodule

// File: rtl/coef_bank_store.sv
module coef_bank_store
  import cbank_pkg::*;
#(
  parameter int NLANE = 1 << IDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_mode,
  input  logic                    cs_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BUS_W-1:0]        wdata,
  input  logic                    rd_rw,
  input  logic                    wr_ds_n,
  output logic [BUS_W-1:0]        rdata,
  input  logic                    sample_tick,
  output logic [NLANE*COEF_W-1:0] coef_out,
  output logic [BANK_W-1:0]       active_bank_out,
  output logic [MODE_W-1:0]       mode_out,
  output logic [DEC_W-1:0]        decim_out,
  output logic [BUS_W-1:0]        gain_out
);
  localparam int COEF_SPACE = ADDR_W - 1;

  logic wr_pulse, rd_act;
  logic wr_cfg, wr_gain, wr_coef;
  logic reg_space_hit0, reg_space_hit1;
  cfg_t cfg;
  logic [BUS_W-1:0] gain;

  cbank_bus_decode u_dec (
    .clk(clk), .rst(rst), .bus_mode(bus_mode), .cs_n(cs_n),
    .rd_rw(rd_rw), .wr_ds_n(wr_ds_n), .wr_pulse(wr_pulse), .rd_act(rd_act)
  );

  assign reg_space_hit0 = !addr[COEF_SPACE] && (addr[COEF_SPACE-1:0] == '0);
  assign reg_space_hit1 = !addr[COEF_SPACE] && (addr[COEF_SPACE-1:0] == 1);
  assign wr_cfg  = wr_pulse && reg_space_hit0;
  assign wr_gain = wr_pulse && reg_space_hit1;
  assign wr_coef = wr_pulse && addr[COEF_SPACE];

  cbank_regs u_regs (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wr_gain(wr_gain),
    .wdata(wdata), .cfg(cfg), .gain(gain)
  );

  // coefficient lanes: one storage column per in-bank index
  logic [COEF_W-1:0] lane_dp  [NLANE];
  logic [COEF_W-1:0] lane_bus [NLANE];
  logic [IDX_W-1:0]  w_idx;
  assign w_idx = wdata[BUS_W-1:COEF_W];

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    cbank_lane #(.BANK_W(BANK_W), .CW(COEF_W)) u_lane (
      .clk(clk),
      .we(wr_coef && (w_idx == IDX_W'(i))),
      .wbank(cfg.load),
      .wval(wdata[COEF_W-1:0]),
      .dp_bank(cfg.active),
      .bus_bank(cfg.load),
      .dp_q(lane_dp[i]),
      .bus_q(lane_bus[i])
    );
  end

  // sample-boundary staging of the running bank
  logic [BANK_W-1:0]       bank_rd_d;
  logic [BANK_W-1:0]       bank_run;
  logic [NLANE*COEF_W-1:0] coef_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_rd_d <= '0;
      bank_run  <= '0;
      coef_run  <= '0;
    end else begin
      bank_rd_d <= cfg.active;
      if (sample_tick) begin
        bank_run <= bank_rd_d;
        for (int i = 0; i < NLANE; i++) coef_run[i*COEF_W +: COEF_W] <= lane_dp[i];
      end
    end
  end

  // two-stage read pipeline
  logic             rd_q, coef_q;
  rsel_e            rsel_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      coef_q <= 1'b0;
      rsel_q <= RSEL_NONE;
      idx_q  <= '0;
      rdata  <= '0;
    end else begin
      rd_q   <= rd_act;
      coef_q <= addr[COEF_SPACE];
      idx_q  <= addr[IDX_W-1:0];
      if (reg_space_hit0)      rsel_q <= RSEL_CFG;
      else if (reg_space_hit1) rsel_q <= RSEL_GAIN;
      else                     rsel_q <= RSEL_NONE;

      if (!rd_q)                  rdata <= '0;
      else if (coef_q)            rdata <= {{(BUS_W-COEF_W){1'b0}}, lane_bus[idx_q]};
      else if (rsel_q == RSEL_CFG)  rdata <= {{(BUS_W-CFG_W){1'b0}}, cfg};
      else if (rsel_q == RSEL_GAIN) rdata <= gain;
      else                        rdata <= '0;
    end
  end

  assign coef_out        = coef_run;
  assign active_bank_out = bank_run;
  assign mode_out        = cfg.mode;
  assign decim_out       = cfg.decim;
  assign gain_out        = gain;

  a_r8_coef_stable_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !sample_tick |=> $stable(coef_out));
  a_r8_bank_stable_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !sample_tick |=> $stable(active_bank_out));
  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_act |-> ##2 (rdata == '0));
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (coef_out == '0 && active_bank_out == '0 && rdata == '0));
endmodule

// File: tb/coef_bank_store_test.sv
module coef_bank_store_test;
  import cbank_pkg::*;

  localparam int NL = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_mode = 1'b0;
  logic cs_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [BUS_W-1:0]  wdata = '0;
  logic rd_rw = 1'b1;
  logic wr_ds_n = 1'b1;
  logic sample_tick = 1'b0;
  logic [BUS_W-1:0]       rdata;
  logic [NL*COEF_W-1:0]   coef_out;
  logic [BANK_W-1:0]      active_bank_out;
  logic [MODE_W-1:0]      mode_out;
  logic [DEC_W-1:0]       decim_out;
  logic [BUS_W-1:0]       gain_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  coef_bank_store uut (
    .clk(clk), .rst(rst), .bus_mode(bus_mode), .cs_n(cs_n), .addr(addr),
    .wdata(wdata), .rd_rw(rd_rw), .wr_ds_n(wr_ds_n), .rdata(rdata),
    .sample_tick(sample_tick), .coef_out(coef_out),
    .active_bank_out(active_bank_out), .mode_out(mode_out),
    .decim_out(decim_out), .gain_out(gain_out)
  );

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] adr;
    logic [BUS_W-1:0]  dat;
    logic [3:0]        req;
  } vec_t;

  // rd=0: write dat to adr; rd=1: read adr and expect dat
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'h00, 16'h0003, 4'd4},  // R4 load bank 3
    '{1'b0, 5'h10, 16'h5ABC, 4'd2},  // R2 index 5
    '{1'b0, 5'h13, 16'hF123, 4'd2},  // R2 index 15, addr low bits ignored
    '{1'b1, 5'h15, 16'h0ABC, 4'd2},
    '{1'b1, 5'h1F, 16'h0123, 4'd2},
    '{1'b0, 5'h00, 16'h0004, 4'd3},  // R3 load bank 4
    '{1'b0, 5'h10, 16'h5777, 4'd3},
    '{1'b1, 5'h15, 16'h0777, 4'd3},
    '{1'b0, 5'h00, 16'h0003, 4'd3},
    '{1'b1, 5'h15, 16'h0ABC, 4'd3},  // R3 bank 3 untouched
    '{1'b0, 5'h01, 16'hBEEF, 4'd6},  // R6 gain
    '{1'b1, 5'h01, 16'hBEEF, 4'd6},
    '{1'b0, 5'h00, 16'hFFFF, 4'd5},  // R5 code 7 clamps to 4
    '{1'b1, 5'h00, 16'h13FF, 4'd5},
    '{1'b0, 5'h00, 16'h0A53, 4'd4},  // R4 fields
    '{1'b1, 5'h00, 16'h0A53, 4'd4}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic set_idle();
    cs_n = 1'b1; rd_rw = 1'b1; wr_ds_n = 1'b1;
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 1'b0;
    if (!bus_mode) begin rd_rw = 1'b1; wr_ds_n = 1'b0; end
    else           begin rd_rw = 1'b0; wr_ds_n = 1'b0; end
    @(negedge clk);
    set_idle();
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [BUS_W-1:0] d);
    @(negedge clk);
    addr = a; cs_n = 1'b0;
    if (!bus_mode) begin rd_rw = 1'b0; wr_ds_n = 1'b1; end
    else           begin rd_rw = 1'b1; wr_ds_n = 1'b0; end
    @(negedge clk);
    @(negedge clk);
    d = rdata;
    set_idle();
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
  endtask

  function automatic logic [COEF_W-1:0] lane(input int i);
    return coef_out[i*COEF_W +: COEF_W];
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [BUS_W-1:0] rv;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 coef_out", 32'(coef_out[31:0]), 32'h0);
    check("R1 active_bank_out", 32'(active_bank_out), 32'h0);
    check("R1 gain_out", 32'(gain_out), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    bus_read(5'h00, rv); check("R1 cfg read", 32'(rv), 32'h0);
    bus_read(5'h01, rv); check("R1 gain read", 32'(rv), 32'h0);
    check("R1 rdata idle", 32'(rdata), 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (!VECS[v].rd) bus_write(VECS[v].adr, VECS[v].dat);
      else begin
        bus_read(VECS[v].adr, rv);
        check($sformatf("R%0d vector %0d", VECS[v].req, v), 32'(rv), 32'(VECS[v].dat));
      end
    end
    check("R4 mode_out", 32'(mode_out), 32'h2);
    check("R4 decim_out", 32'(decim_out), 32'h2);
    bus_write(5'h00, 16'h1C00);
    check("R5 decim_out clamp", 32'(decim_out), 32'h4);

    // R7 / R8 parallel presentation and boundary staging
    bus_write(5'h00, 16'h0011);
    for (int i = 0; i < NL; i++) bus_write(5'h10, {4'(i), 12'(12'h100 + i)});
    bus_write(5'h00, 16'h0012);
    for (int i = 0; i < NL; i++) bus_write(5'h10, {4'(i), 12'(12'h200 + i)});
    check("R8 no tick yet", 32'(lane(0)), 32'h0);
    tick();
    for (int i = 0; i < NL; i++) check($sformatf("R7 bank1 lane %0d", i), 32'(lane(i)), 32'(12'h100 + i));
    check("R7 active bank 1", 32'(active_bank_out), 32'h1);
    bus_write(5'h00, 16'h0022);
    repeat (3) @(negedge clk);
    check("R8 bank switch held", 32'(lane(3)), 32'h103);
    check("R8 bank number held", 32'(active_bank_out), 32'h1);
    tick();
    for (int i = 0; i < NL; i++) check($sformatf("R7 bank2 lane %0d", i), 32'(lane(i)), 32'(12'h200 + i));
    check("R7 active bank 2", 32'(active_bank_out), 32'h2);
    bus_write(5'h10, 16'h0ABC);
    repeat (3) @(negedge clk);
    check("R8 running-bank write held", 32'(lane(0)), 32'h200);
    tick();
    check("R8 write applied at boundary", 32'(lane(0)), 32'hABC);

    // R9 second strobe style
    bus_mode = 1'b1;
    @(negedge clk);
    bus_write(5'h01, 16'h1234);
    bus_read(5'h01, rv); check("R9 strobe-style gain", 32'(rv), 32'h1234);
    bus_write(5'h10, 16'h7456);
    bus_read(5'h17, rv); check("R9 strobe-style coef", 32'(rv), 32'h0456);
    bus_mode = 1'b0;
    @(negedge clk);

    // R10 held write strobe, data changed after first clock
    @(negedge clk);
    addr = 5'h10; wdata = 16'h1055; cs_n = 1'b0; rd_rw = 1'b1; wr_ds_n = 1'b0;
    @(negedge clk); wdata = 16'h1066;
    @(negedge clk); @(negedge clk);
    set_idle();
    @(negedge clk);
    bus_read(5'h11, rv); check("R10 single write", 32'(rv), 32'h0055);

    // R12 both strobes low
    @(negedge clk);
    addr = 5'h01; wdata = 16'h9999; cs_n = 1'b0; rd_rw = 1'b0; wr_ds_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R12 no read data", 32'(rdata), 32'h0);
    set_idle();
    @(negedge clk);
    bus_read(5'h01, rv); check("R12 gain unchanged", 32'(rv), 32'h1234);

    // R13 chip select high
    @(negedge clk);
    addr = 5'h01; wdata = 16'h5555; cs_n = 1'b1; rd_rw = 1'b1; wr_ds_n = 1'b0;
    @(negedge clk); @(negedge clk);
    set_idle();
    @(negedge clk);
    check("R13 gain_out unchanged", 32'(gain_out), 32'h1234);

    // R11 latency and idle zero
    bus_read(5'h00, rv); check("R11 cfg after two clocks", 32'(rv), 32'h0022);
    repeat (2) @(negedge clk);
    check("R11 idle rdata", 32'(rdata), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule